// File: doc/BRIEF.md
# Remote-Power Discovery Sequencer (single port)

This block is the per-port control logic that finds a remotely powered terminal on a link and decides how link negotiation restarts when the link does not come up. Each port of a multi-port transceiver gets its own copy, and no state is shared between copies. Discovery runs only while both the discovery enable and the auto-negotiation enable are set. A detector outside this block reports a powered terminal with a one-cycle pulse. The block then raises a sticky power-enable status bit, which system software reads before it switches the terminal's supply on.

Raising power-enable also arms an internal link-fail-inhibit timer with a length set by a parameter. If the link comes up before the timer runs out, the timer is disarmed. If it runs out with the link still down, the block emits a one-cycle restart strobe. A flag in the same cycle says whether the new negotiation round includes terminal detection. That depends on the negotiation mode and on the discovery enable at the moment of expiry. The discovery enable also goes straight out to the advertised base page without delay.

Top module: `rpd_sequencer`

## Requirements
- R1: `adv_disc_o` equals `disc_en_i` in the same cycle, with no register in between.
- R2: A `det_i` pulse is ignored, and `pwr_en_o` stays 0, unless both `disc_en_i` and `an_en_i` are 1 in that cycle.
- R3: A `det_i` pulse while `disc_en_i` and `an_en_i` are both 1 sets `pwr_en_o` at the next clock edge. It then stays set until a clearing event from R4, R5 or R6.
- R4: `pwr_en_o` is 0 after any clock edge at which `disc_en_i` was 0.
- R5: If `link_up_i` falls from 1 to 0 while `pwr_en_o` is 1, `pwr_en_o` is 0 after that edge.
- R6: The timer arms at the edge where `pwr_en_o` rises. If `link_up_i` stays 0, `restart_o` rises exactly `LFI_CYCLES` clock edges later, and `pwr_en_o` clears at that same edge.
- R7: `link_up_i` = 1 in any cycle before expiry, including the expiry cycle itself, disarms the timer, and no restart follows from that arming.
- R8: `restart_o` is high for exactly one cycle. `restart_det_o` is 1 only together with `restart_o`, and only if, in the expiry cycle, `an_en_i`=1, `forced_i`=0 and `disc_en_i`=1. Otherwise it is 0.
- R9: While `rst_n` is low, and right after reset, `pwr_en_o`, `restart_o` and `restart_det_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disc_en_i | input | 1 | Discovery enable for this port |
| an_en_i | input | 1 | Auto-negotiation enable |
| forced_i | input | 1 | Forced-speed mode in use |
| det_i | input | 1 | One-cycle pulse: powered terminal detected |
| link_up_i | input | 1 | Link status |
| adv_disc_o | output | 1 | Discovery bit for the advertised base page |
| pwr_en_o | output | 1 | Sticky power-enable status |
| restart_o | output | 1 | One-cycle restart-negotiation strobe |
| restart_det_o | output | 1 | Restart includes terminal detection (valid with restart_o) |

## Verification
Two events can land in the same cycle: the link coming up and the timer's final count. The bench provokes this directly by raising the link in exactly the cycle the timer would expire, and expects no strobe. A detection pulse can also coincide with a disable. The random phase toggles the discovery enable while detection pulses arrive, and a per-cycle model judges each case: a clear always wins over a set, and a link-up always wins over an expiry.

// File: rtl/rpd_pkg.sv
package rpd_pkg;

  typedef struct packed {
    logic fire;
    logic detect;
  } rpd_restart_t;

  // timer reaches its last count
  function automatic logic timer_hit(int unsigned count, int unsigned limit);
    return (count + 1) == limit;
  endfunction

  // restart with terminal detection only in auto-negotiation with discovery on
  function automatic logic with_detect(logic an_en, logic forced, logic disc_en);
    return an_en & ~forced & disc_en;
  endfunction

endpackage

// File: rtl/rpd_power.sv
module rpd_power (
  input  logic clk,
  input  logic rst_n,
  input  logic disc_en_i,
  input  logic an_en_i,
  input  logic det_i,
  input  logic link_up_i,
  input  logic expire_i,
  output logic pwr_en_o,
  output logic set_o
);
  logic link_q;
  logic link_fall;
  logic clr;

  assign link_fall = link_q & ~link_up_i;
  assign set_o     = disc_en_i & an_en_i & det_i & ~pwr_en_o;
  assign clr       = ~disc_en_i | (pwr_en_o & link_fall) | expire_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_en_o <= 1'b0;
      link_q   <= 1'b0;
    end else begin
      link_q <= link_up_i;
      if (clr)        pwr_en_o <= 1'b0;
      else if (set_o) pwr_en_o <= 1'b1;
    end
  end

  p_set_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en_o) |-> $past(det_i && disc_en_i && an_en_i));
  p_disable_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !disc_en_i |=> !pwr_en_o);
  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_en_o && !(disc_en_i && an_en_i)) |=> !pwr_en_o);
endmodule

// File: rtl/rpd_lfi_timer.sv
module rpd_lfi_timer #(
  parameter int unsigned LFI_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic link_up_i,
  output logic expire_o
);
  import rpd_pkg::*;
  localparam int unsigned CW = $clog2(LFI_CYCLES + 1);

  logic          armed;
  logic [CW-1:0] cnt;

  assign expire_o = armed & ~link_up_i & timer_hit(int'(cnt), LFI_CYCLES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (arm_i) begin
      armed <= 1'b1;
      cnt   <= '0;
    end else if (link_up_i || expire_o) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (armed) begin
      cnt <= cnt + 1'b1;
    end
  end

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (int'(cnt) < LFI_CYCLES));
  p_link_disarms_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up_i && !arm_i) |=> !armed);
endmodule

// File: rtl/rpd_restart.sv
module rpd_restart (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic an_en_i,
  input  logic forced_i,
  input  logic disc_en_i,
  output logic restart_o,
  output logic restart_det_o
);
  import rpd_pkg::*;
  rpd_restart_t req_d, req_q;

  always_comb begin
    req_d.fire   = expire_i;
    req_d.detect = expire_i & with_detect(an_en_i, forced_i, disc_en_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end

  assign restart_o     = req_q.fire;
  assign restart_det_o = req_q.detect;

  p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> !restart_o);
  p_flag_with_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart_det_o |-> restart_o);
  p_forced_no_detect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_i && forced_i) |=> (restart_o && !restart_det_o));
endmodule

// File: rtl/rpd_sequencer.sv
module rpd_sequencer #(
  parameter int unsigned LFI_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic disc_en_i,
  input  logic an_en_i,
  input  logic forced_i,
  input  logic det_i,
  input  logic link_up_i,
  output logic adv_disc_o,
  output logic pwr_en_o,
  output logic restart_o,
  output logic restart_det_o
);
  logic pwr_set;
  logic expire;

  assign adv_disc_o = disc_en_i;

  rpd_power u_power (
    .clk(clk), .rst_n(rst_n), .disc_en_i(disc_en_i), .an_en_i(an_en_i),
    .det_i(det_i), .link_up_i(link_up_i), .expire_i(expire),
    .pwr_en_o(pwr_en_o), .set_o(pwr_set)
  );

  rpd_lfi_timer #(.LFI_CYCLES(LFI_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm_i(pwr_set), .link_up_i(link_up_i),
    .expire_o(expire)
  );

  rpd_restart u_restart (
    .clk(clk), .rst_n(rst_n), .expire_i(expire), .an_en_i(an_en_i),
    .forced_i(forced_i), .disc_en_i(disc_en_i),
    .restart_o(restart_o), .restart_det_o(restart_det_o)
  );

  p_no_restart_on_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |-> !$past(link_up_i));
  p_restart_drops_power_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |-> !pwr_en_o || $past(pwr_set));
endmodule

// File: tb/rpd_sequencer_bench.sv
module rpd_sequencer_bench;
  localparam int unsigned LFI = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disc_en, an_en, forced, det, link_up;
  logic adv, pwr, rs, rsd;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  bit m_pwr, m_arm, m_link, m_rs, m_rsd;
  int m_left;

  always #10 clk = ~clk;

  rpd_sequencer #(.LFI_CYCLES(LFI)) u_rpd_sequencer (
    .clk(clk), .rst_n(rst_n), .disc_en_i(disc_en), .an_en_i(an_en),
    .forced_i(forced), .det_i(det), .link_up_i(link_up),
    .adv_disc_o(adv), .pwr_en_o(pwr), .restart_o(rs), .restart_det_o(rsd)
  );

  function automatic bit exp_detect(bit a, bit f, bit d);
    return a && !f && d;
  endfunction

  task automatic check(string req, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, expv, $time);
    end
  endtask

  // drive one cycle of inputs, advance the model, compare after the edge
  task automatic step(bit d, bit a, bit f, bit dt, bit lu);
    bit fall, ex, st;
    disc_en = d; an_en = a; forced = f; det = dt; link_up = lu;
    #1;
    check("R1 adv", adv, d);
    fall = m_link && !lu;
    ex   = m_arm && !lu && (m_left == 1);
    st   = d && a && dt && !m_pwr;
    m_rs  = ex;
    m_rsd = ex && exp_detect(a, f, d);
    if (!d || (m_pwr && fall) || ex) m_pwr = 0;
    else if (st) m_pwr = 1;
    if (st) begin m_arm = 1; m_left = LFI; end
    else if (lu || ex) m_arm = 0;
    else if (m_arm) m_left--;
    m_link = lu;
    @(posedge clk);
    @(negedge clk);
    check("R3/R4/R5 pwr_en", pwr, m_pwr);
    check("R6/R7 restart", rs, m_rs);
    check("R8 restart_det", rsd, m_rsd);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_0042));
    disc_en = 0; an_en = 0; forced = 0; det = 0; link_up = 0;
    m_pwr = 0; m_arm = 0; m_link = 0; m_rs = 0; m_rsd = 0; m_left = 0;
    repeat (3) @(negedge clk);
    check("R9 reset pwr", pwr, 1'b0);
    check("R9 reset restart", rs, 1'b0);
    check("R9 reset det", rsd, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset", pwr | rs | rsd, 1'b0);

    // R2: detection ignored without auto-negotiation or discovery
    step(1, 0, 0, 1, 0);
    check("R2 an off", pwr, 1'b0);
    step(0, 1, 0, 1, 0);
    check("R2 disc off", pwr, 1'b0);

    // R6: exact expiry distance, with detection
    step(1, 1, 0, 1, 0);
    check("R3 set", pwr, 1'b1);
    n = 0;
    while (!rs && n < 3 * LFI) begin step(1, 1, 0, 0, 0); n++; end
    check("R6 distance", (n == LFI), 1'b1);
    check("R8 detect flag", rsd, 1'b1);
    check("R6 pwr cleared", pwr, 1'b0);
    step(1, 1, 0, 0, 0);
    check("R8 single pulse", rs, 1'b0);

    // R7: link up exactly in the expiry cycle
    step(1, 1, 0, 1, 0);
    for (int i = 0; i < LFI - 1; i++) step(1, 1, 0, 0, 0);
    step(1, 1, 0, 0, 1);
    check("R7 collision", rs, 1'b0);
    for (int i = 0; i < 2 * LFI; i++) step(1, 1, 0, 0, 1);
    check("R3 sticky", pwr, 1'b1);

    // R5: link falls while powered
    step(1, 1, 0, 0, 0);
    check("R5 link down", pwr, 1'b0);

    // R8: forced mode restart without detection
    step(1, 1, 0, 1, 0);
    for (int i = 0; i < LFI - 1; i++) step(1, 1, 1, 0, 0);
    step(1, 1, 1, 0, 0);
    check("R8 forced fire", rs, 1'b1);
    check("R8 forced nodet", rsd, 1'b0);

    // R4/R8: discovery dropped after arming; timer still expires, no detection
    step(1, 1, 0, 1, 0);
    step(0, 1, 0, 0, 0);
    check("R4 disable", pwr, 1'b0);
    for (int i = 0; i < LFI - 1; i++) step(0, 1, 0, 0, 0);
    check("R8 disc-off fire", rs, 1'b1);
    check("R8 disc-off nodet", rsd, 1'b0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      bit d, a, f, dt, lu;
      d  = ($urandom % 100) < 92;
      a  = ($urandom % 100) < 90;
      f  = ($urandom % 100) < 20;
      dt = ($urandom % 100) < 6;
      lu = (($urandom % 100) < 4) ? !m_link : m_link;
      step(d, a, f, dt, lu);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule